// File: doc/BRIEF.md
# Phase-Interleaved Video RAM Arbiter

This block lets a processor and a character-display fetch path share one RAM without wait states. A divider running on the dot clock splits every bus cycle into two equal halves. In the first half the video side owns the RAM. The scan address is driven, the RAM is read, and the fetched character code is captured in a holding register. In the second half the processor owns the RAM and may read or write it. The two halves come out as a pair of non-overlapping phase clocks, `phi1` (video) and `phi2` (processor).

The capture strobe is high whenever the processor half is active. In the video half it is high only during the upper half, where divider tap bit `TAP` is set. The RAM select is released when that strobe rises and stays released until the processor half begins. This means the select is never active while the data path changes hands from video to processor, so a stale write cannot reach the RAM during the handover.

Every output is registered and changes only on the dot clock. All outputs are computed from the next divider value, so each output lines up with the divider slot it belongs to. With the default `DIV` = 8, each bus cycle has 8 slots numbered 0 to 7, and the tap is bit 1.

Top module: `vram_arbiter`

## Requirements
- R1: While `rst` is high, the block holds `phi1`=0, `phi2`=0, `ram_cs_n`=1, `ram_we_n`=1, `latch_stb`=1, `ram_addr`=0, `ram_wdata`=0 and `char_q`=0. The first dot clock after reset is released enters slot 0.
- R2: `phi1` is 1 in slots 0..DIV/2-1 and `phi2` is 1 in slots DIV/2..DIV-1. The slot advances by one each dot clock and wraps after DIV-1. The two phases are never 1 together.
- R3: `ram_addr` equals `vid_addr` in video slots and `cpu_addr` in processor slots. In processor slots `ram_wdata` equals `cpu_wdata`.
- R4: `latch_stb` is 1 in every processor slot. In a video slot it equals bit TAP of the slot number, where TAP = log2(DIV)-2. With DIV=8 it is 0 in slots 0,1 and 1 in slots 2..7.
- R5: In video slots `ram_cs_n` equals `latch_stb`. The select is active (0) only in the first part of the video half and is inactive at the last video slot before the handover.
- R6: In processor slots `ram_cs_n` is the inverse of `cpu_req`.
- R7: `ram_we_n` is 0 only in processor slots where both `cpu_req` and `cpu_wr` are 1. Video slots force it to 1.
- R8: `char_q` takes the value of `ram_rdata` on the dot clock where `latch_stb` rises from 0 to 1, and holds at all other times, including through processor writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor selects the RAM this bus cycle |
| cpu_wr | input | 1 | Processor access is a write |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| vid_addr | input | AW | Scan address of the current character cell |
| ram_rdata | input | DW | RAM read data |
| phi1 | output | 1 | Video phase clock |
| phi2 | output | 1 | Processor phase clock |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| latch_stb | output | 1 | Character capture strobe |
| char_q | output | DW | Captured character code |

## Verification
The critical coincidence is the video-to-processor handover landing in the same bus cycle as a processor write request. On that edge the address mux flips and the write enable falls, while the capture register must hold and the select must have been released since the strobe rose. The bench sweeps every combination of request and write across 64 bus cycles, with addresses and data changing each cycle. In every slot it compares each output against values computed from the slot number. It also follows the captured code through the processor half, so that any capture or select glitch at the handover shows up as a mismatch.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;
  typedef enum logic {OWN_VIDEO = 1'b0, OWN_CPU = 1'b1} owner_e;
endpackage

// File: rtl/vram_phase_gen.sv
module vram_phase_gen
  import vram_arb_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic   clk,
  input  logic   rst,
  output owner_e nxt_owner,
  output logic   nxt_tap,
  output logic   phi1,
  output logic   phi2
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;
  localparam int TAP  = CW - 2;

  logic [CW-1:0] slot, slot_nx;

  always_comb begin
    slot_nx   = (slot == CW'(DIV - 1)) ? '0 : slot + 1'b1;
    nxt_owner = (slot_nx < CW'(HALF)) ? OWN_VIDEO : OWN_CPU;
    nxt_tap   = slot_nx[TAP];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= CW'(DIV - 1);
      phi1 <= 1'b0;
      phi2 <= 1'b0;
    end else begin
      slot <= slot_nx;
      phi1 <= (nxt_owner == OWN_VIDEO);
      phi2 <= (nxt_owner == OWN_CPU);
    end
  end

  a_r2_phases_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(phi1 && phi2));
  a_r2_video_first: assert property (@(posedge clk) disable iff (rst)
    (slot == '0) |-> phi1);
endmodule

// File: rtl/vram_port_mux.sv
module vram_port_mux
  import vram_arb_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  owner_e        nxt_owner,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [AW-1:0] vid_addr,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_addr <= (nxt_owner == OWN_VIDEO) ? vid_addr : cpu_addr;
      if (nxt_owner == OWN_CPU) ram_wdata <= cpu_wdata;
    end
  end
endmodule

// File: rtl/vram_strobe_ctrl.sv
module vram_strobe_ctrl
  import vram_arb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  owner_e        nxt_owner,
  input  logic          nxt_tap,
  input  logic          cpu_req,
  input  logic          cpu_wr,
  input  logic [DW-1:0] ram_rdata,
  output logic          ram_cs_n,
  output logic          ram_we_n,
  output logic          latch_stb,
  output logic [DW-1:0] char_q
);
  logic stb_nx, cs_nx_n, we_nx_n;

  always_comb begin
    stb_nx  = (nxt_owner == OWN_CPU) || nxt_tap;
    cs_nx_n = (nxt_owner == OWN_VIDEO) ? stb_nx : !cpu_req;
    we_nx_n = !((nxt_owner == OWN_CPU) && cpu_req && cpu_wr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_cs_n  <= 1'b1;
      ram_we_n  <= 1'b1;
      latch_stb <= 1'b1;
      char_q    <= '0;
    end else begin
      ram_cs_n  <= cs_nx_n;
      ram_we_n  <= we_nx_n;
      latch_stb <= stb_nx;
      if (stb_nx && !latch_stb) char_q <= ram_rdata;
    end
  end

  a_r7_write_needs_select: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> !ram_cs_n);
  a_r5_select_off_at_capture: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_stb) |-> ram_cs_n);
  a_r8_char_hold: assert property (@(posedge clk) disable iff (rst)
    !$rose(latch_stb) |-> $stable(char_q));
endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter
  import vram_arb_pkg::*;
#(
  parameter int DIV = 8,
  parameter int AW  = 12,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [AW-1:0] vid_addr,
  input  logic [DW-1:0] ram_rdata,
  output logic          phi1,
  output logic          phi2,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_cs_n,
  output logic          ram_we_n,
  output logic          latch_stb,
  output logic [DW-1:0] char_q
);
  owner_e nxt_owner;
  logic   nxt_tap;

  vram_phase_gen #(.DIV(DIV)) u_phase (
    .clk(clk), .rst(rst), .nxt_owner(nxt_owner), .nxt_tap(nxt_tap),
    .phi1(phi1), .phi2(phi2)
  );

  vram_port_mux #(.AW(AW), .DW(DW)) u_mux (
    .clk(clk), .rst(rst), .nxt_owner(nxt_owner),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .vid_addr(vid_addr),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  vram_strobe_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .nxt_owner(nxt_owner), .nxt_tap(nxt_tap),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .ram_rdata(ram_rdata),
    .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n), .latch_stb(latch_stb),
    .char_q(char_q)
  );

  a_r4_strobe_high_in_cpu: assert property (@(posedge clk) disable iff (rst)
    phi2 |-> latch_stb);
  a_r7_no_write_in_video: assert property (@(posedge clk) disable iff (rst)
    phi1 |-> ram_we_n);
endmodule

// File: tb/tb_vram_arbiter.sv
`timescale 1ns/1ps
module tb_vram_arbiter;
  localparam int DIV = 8;
  localparam int AW  = 12;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_wr = 1'b0;
  logic [AW-1:0] cpu_addr = '0, vid_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] ram_rdata;
  logic phi1, phi2, ram_cs_n, ram_we_n, latch_stb;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, char_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  assign ram_rdata = ram_addr[7:0] ^ 8'h5A;

  vram_arbiter #(.DIV(DIV), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .vid_addr(vid_addr),
    .ram_rdata(ram_rdata), .phi1(phi1), .phi2(phi2), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
    .latch_stb(latch_stb), .char_q(char_q)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_inputs(input int p);
    cpu_req   = p[0];
    cpu_wr    = p[1];
    cpu_addr  = AW'(p * 37 + 5);
    vid_addr  = AW'(p * 91 + 3);
    cpu_wdata = DW'(p * 13 + 1);
  endtask

  initial begin
    logic [DW-1:0] exp_char;
    exp_char = '0;
    set_inputs(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 phi1", phi1, 0);       chk("R1 phi2", phi2, 0);
    chk("R1 cs_n", ram_cs_n, 1);   chk("R1 we_n", ram_we_n, 1);
    chk("R1 stb", latch_stb, 1);   chk("R1 addr", ram_addr, 0);
    chk("R1 wdata", ram_wdata, 0); chk("R1 char", char_q, 0);
    rst = 1'b0;
    for (int p = 0; p < 64; p++) begin
      for (int s = 0; s < DIV; s++) begin
        bit video, stb, cs_n, we_n;
        @(posedge clk);
        @(negedge clk);
        video = (s < DIV / 2);
        stb   = !video || ((s >> 1) & 1) == 1;
        cs_n  = video ? stb : !cpu_req;
        we_n  = !(!video && cpu_req && cpu_wr);
        if (s == 2) exp_char = vid_addr[7:0] ^ 8'h5A;
        chk("R2 phi1", phi1, video);
        chk("R2 phi2", phi2, !video);
        chk("R3 addr", ram_addr, video ? vid_addr : cpu_addr);
        if (!video) chk("R3 wdata", ram_wdata, cpu_wdata);
        chk("R4 stb", latch_stb, stb);
        if (video) chk("R5 cs_n video", ram_cs_n, cs_n);
        else       chk("R6 cs_n cpu", ram_cs_n, cs_n);
        chk("R7 we_n", ram_we_n, we_n);
        chk("R8 char", char_q, exp_char);
        if (s == DIV - 1) set_inputs(p + 1);
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule